// File: doc/BRIEF.md
# Accumulator Machine Instruction Sequencer

This block is the control unit and datapath of a small 16-bit accumulator computer. Each instruction takes a fixed sequence of timing steps. A step counter advances once per clock. In the first steps the block reads the instruction word from memory and increments the program counter. It then sorts the word into one of three classes: memory operation, register operation or input transfer. The remaining steps execute it. When the instruction is done, the step counter returns to zero and the next fetch begins.

Memory is external. Its address comes from a register inside the block, so the address holds steady for the whole cycle. Read data must be valid in that same cycle. A write happens at the clock edge that ends a cycle in which the write enable is high. An 8-bit character can be loaded into an input holding register with a strobe, which sets a full flag. An input instruction moves the held character into the low byte of the accumulator and clears the flag.

The instruction word has three fields. Bits 11..0 hold the address. Bits 14..12 hold the opcode. Bit 15 is the mode bit. Opcode 111 selects a register operation when the mode bit is 0 and an input/output operation when it is 1. Every other opcode is a memory operation, and for those the mode bit selects indirect addressing.

Top module: `acc_seq_top`

## Requirements
- R1: While reset is high, the program counter, accumulator, carry flag E, step counter and input full flag read zero, and the memory write enable is low.
- R2: Fetch timing: in step 0 the address register takes the PC. In step 1, mem_addr equals the PC, the word read becomes the instruction, and the PC increments at the end of the step. Step 2 loads the address register from instruction bits 11..0. The step counter then advances by one each cycle until the instruction ends.
- R3: For a memory operation with bit 15 = 0, the effective address seen on mem_addr in step 4 is instruction bits 11..0.
- R4: For a memory operation with bit 15 = 1, in step 3 the address register is replaced by bits 11..0 of the word it points to, and that value is the effective address from step 4 on.
- R5: Opcode 001 (ADD) reads the operand in step 4 and sets {E, AC} to the 17-bit sum AC + operand in step 5. The instruction takes 6 cycles.
- R6: Opcode 000 (AND) sets AC to AC AND operand, and opcode 010 (LDA) sets AC to the operand. Both take 6 cycles and leave E unchanged.
- R7: Opcode 011 (STA) drives mem_we high only in step 4, writing AC to the effective address. It takes 5 cycles. mem_we is low in every other cycle.
- R8: Opcode 100 (BUN) loads the PC with the effective address in step 4. It takes 5 cycles.
- R9: Opcodes 101 and 110 change no register and no memory. They take 5 cycles.
- R10: A register operation (opcode 111, bit 15 = 0) takes 4 cycles. Its low bits act as follows: bit 11 clears AC, bit 10 clears E, bit 9 complements AC, bit 8 complements E. The clears are applied before the complements.
- R11: An input/output operation (opcode 111, bit 15 = 1) takes 4 cycles. When bit 11 is set, it copies the held character into AC bits 7..0, keeps AC bits 15..8, and clears in_full. When bit 11 is clear, it has no effect.
- R12: A high in_load captures in_char and sets in_full at the next edge. If it coincides with the step in which an input operation clears the flag, the set wins, and the input operation uses the previously held character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory address, held in a register |
| mem_rdata | input | 16 | Memory read data for mem_addr, valid in the same cycle |
| mem_wdata | output | 16 | Memory write data (the accumulator) |
| mem_we | output | 1 | Memory write enable, takes effect at the clock edge |
| in_load | input | 1 | Strobe that captures in_char and sets the full flag |
| in_char | input | 8 | Input character |
| in_full | output | 1 | Input holding register contains an unread character |
| acc_out | output | 16 | Accumulator |
| e_out | output | 1 | Carry / extension flag E |
| pc_out | output | 12 | Program counter |
| sc_out | output | 3 | Current timing step |

## Verification
A wrong decode or a wrong step sequence shows first on sc_out. The counter returns to zero one or two cycles early or late, and the PC and AC checks made at the end of that same instruction miss. A corrupted address register appears on mem_addr in step 1 or step 4 of the affected instruction. A corrupted accumulator, E flag or input flag appears on acc_out, e_out and in_full as soon as the instruction ends. Every instruction is compared against an arithmetic model in the bench, so a fault surfaces within one instruction.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    localparam int WORD_W  = 16;
    localparam int ADDR_W  = 12;
    localparam int CHAR_W  = 8;
    localparam int N_STEPS = 6;
    localparam int SC_W    = $clog2(N_STEPS);

    // bit positions inside the low field of register / io words
    localparam int RB_CLR_AC = 11;
    localparam int RB_CLR_E  = 10;
    localparam int RB_CPL_AC = 9;
    localparam int RB_CPL_E  = 8;
    localparam int IB_READ   = 11;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_ADD  = 3'd1,
        OP_LDA  = 3'd2,
        OP_STA  = 3'd3,
        OP_BUN  = 3'd4,
        OP_NOP5 = 3'd5,
        OP_NOP6 = 3'd6,
        OP_SYS  = 3'd7
    } opc_e;

    typedef struct packed {
        logic  mode;
        opc_e  opc;
        addr_t addr;
    } instr_t;

    typedef enum logic [1:0] {
        CLS_MEM,
        CLS_REG,
        CLS_IO
    } iclass_e;

    typedef enum logic [2:0] {
        AC_HOLD,
        AC_AND,
        AC_ADD,
        AC_LOAD,
        AC_REG,
        AC_INP
    } acop_e;

    typedef struct packed {
        logic  ar_from_pc;
        logic  ar_from_ir;
        logic  ar_from_mem;
        logic  ir_load;
        logic  pc_inc;
        logic  pc_from_ar;
        logic  dr_load;
        logic  mem_we;
        logic  sc_clr;
        acop_e acop;
    } ctrl_t;

    function automatic iclass_e classify(input instr_t i);
        if (i.opc != OP_SYS) return CLS_MEM;
        else if (i.mode)     return CLS_IO;
        else                 return CLS_REG;
    endfunction

    // returns {e, ac} after a register operation; clears precede complements
    function automatic logic [WORD_W:0] reg_apply(input word_t ac, input logic e,
                                                  input addr_t sel);
        word_t a;
        logic  f;
        a = sel[RB_CLR_AC] ? '0 : ac;
        f = sel[RB_CLR_E]  ? 1'b0 : e;
        if (sel[RB_CPL_AC]) a = ~a;
        if (sel[RB_CPL_E])  f = ~f;
        return {f, a};
    endfunction

endpackage

// File: rtl/acc_timing.sv
module acc_timing
    import acc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    output logic [SC_W-1:0]    sc,
    output logic [N_STEPS-1:0] t
);

    always_ff @(posedge clk) begin
        if (rst)      sc <= '0;
        else if (clr) sc <= '0;
        else          sc <= sc + 1'b1;
    end

    for (genvar k = 0; k < N_STEPS; k++) begin : g_step
        assign t[k] = (sc == SC_W'(k));
    end

endmodule

// File: rtl/acc_control.sv
module acc_control
    import acc_seq_pkg::*;
(
    input  logic [N_STEPS-1:0] t,
    input  instr_t             ir,
    output ctrl_t              c
);

    iclass_e cls;
    assign cls = classify(ir);

    always_comb begin
        c = '0;
        c.acop = AC_HOLD;
        if (t[0]) c.ar_from_pc = 1'b1;
        if (t[1]) begin
            c.ir_load = 1'b1;
            c.pc_inc  = 1'b1;
        end
        if (t[2]) c.ar_from_ir = 1'b1;
        if (t[3]) begin
            unique case (cls)
                CLS_MEM: c.ar_from_mem = ir.mode;
                CLS_REG: begin
                    c.acop   = AC_REG;
                    c.sc_clr = 1'b1;
                end
                default: begin
                    if (ir.addr[IB_READ]) c.acop = AC_INP;
                    c.sc_clr = 1'b1;
                end
            endcase
        end
        if (t[4]) begin
            unique case (ir.opc)
                OP_AND, OP_ADD, OP_LDA: c.dr_load = 1'b1;
                OP_STA: begin
                    c.mem_we = 1'b1;
                    c.sc_clr = 1'b1;
                end
                OP_BUN: begin
                    c.pc_from_ar = 1'b1;
                    c.sc_clr     = 1'b1;
                end
                default: c.sc_clr = 1'b1;
            endcase
        end
        if (t[5]) begin
            c.sc_clr = 1'b1;
            unique case (ir.opc)
                OP_AND:  c.acop = AC_AND;
                OP_ADD:  c.acop = AC_ADD;
                OP_LDA:  c.acop = AC_LOAD;
                default: c.acop = AC_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/acc_regs.sv
module acc_regs
    import acc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             c,
    input  word_t             mem_rdata,
    input  logic              in_load,
    input  logic [CHAR_W-1:0] in_char,
    output addr_t             pc,
    output addr_t             ar,
    output instr_t            ir,
    output word_t             ac,
    output logic              e,
    output logic              in_full
);

    word_t             dr;
    logic [CHAR_W-1:0] in_hold;
    logic [WORD_W:0]   sum;
    logic [WORD_W:0]   rres;

    assign sum  = {1'b0, ac} + {1'b0, dr};
    assign rres = reg_apply(ac, e, ir.addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc      <= '0;
            ar      <= '0;
            ir      <= '0;
            ac      <= '0;
            e       <= 1'b0;
            dr      <= '0;
            in_hold <= '0;
            in_full <= 1'b0;
        end else begin
            if (c.ar_from_pc)  ar <= pc;
            if (c.ar_from_ir)  ar <= ir.addr;
            if (c.ar_from_mem) ar <= mem_rdata[ADDR_W-1:0];
            if (c.ir_load)     ir <= instr_t'(mem_rdata);
            if (c.pc_inc)      pc <= pc + 1'b1;
            if (c.pc_from_ar)  pc <= ar;
            if (c.dr_load)     dr <= mem_rdata;
            unique case (c.acop)
                AC_AND:  ac <= ac & dr;
                AC_ADD:  {e, ac} <= sum;
                AC_LOAD: ac <= dr;
                AC_REG:  {e, ac} <= rres;
                AC_INP: begin
                    ac[CHAR_W-1:0] <= in_hold;
                    in_full        <= 1'b0;
                end
                default: ;
            endcase
            if (in_load) begin
                in_hold <= in_char;
                in_full <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/acc_seq_top.sv
module acc_seq_top
    import acc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic              in_load,
    input  logic [CHAR_W-1:0] in_char,
    output logic              in_full,
    output logic [WORD_W-1:0] acc_out,
    output logic              e_out,
    output logic [ADDR_W-1:0] pc_out,
    output logic [SC_W-1:0]   sc_out
);

    logic [N_STEPS-1:0] t;
    ctrl_t              ctl;
    instr_t             ir_q;
    addr_t              ar_q;

    acc_timing u_timing (
        .clk (clk),
        .rst (rst),
        .clr (ctl.sc_clr),
        .sc  (sc_out),
        .t   (t)
    );

    acc_control u_control (
        .t  (t),
        .ir (ir_q),
        .c  (ctl)
    );

    acc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .c         (ctl),
        .mem_rdata (mem_rdata),
        .in_load   (in_load),
        .in_char   (in_char),
        .pc        (pc_out),
        .ar        (ar_q),
        .ir        (ir_q),
        .ac        (acc_out),
        .e         (e_out),
        .in_full   (in_full)
    );

    assign mem_addr  = ar_q;
    assign mem_wdata = acc_out;
    assign mem_we    = ctl.mem_we;

endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk
    import acc_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [SC_W-1:0]   sc,
    input logic [ADDR_W-1:0] pc,
    input logic [WORD_W-1:0] acc,
    input logic              e,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_we,
    input logic              in_load,
    input logic              in_full,
    input instr_t            ir
);

    logic rst_seen = 1'b0;
    always @(posedge clk) if (rst) rst_seen <= 1'b1;

    always @(negedge clk) begin
        if (rst && rst_seen) begin
            a_r1_reset_state: assert (pc == '0 && acc == '0 && sc == '0 && !e
                                      && !in_full && !mem_we);
        end
    end

    a_r2_fetch_address: assert property (@(posedge clk) disable iff (rst)
        (sc == SC_W'(1)) |-> (mem_addr == pc));

    a_r2_pc_increment: assert property (@(posedge clk) disable iff (rst)
        (sc == SC_W'(1)) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

    a_r2_step_bound: assert property (@(posedge clk) disable iff (rst)
        sc < SC_W'(N_STEPS));

    a_r7_write_step: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (sc == SC_W'(4) && ir.opc == OP_STA));

    a_r7_write_data: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wdata == acc));

    a_r10_short_done: assert property (@(posedge clk) disable iff (rst)
        (sc == SC_W'(3) && ir.opc == OP_SYS) |=> (sc == '0));

    a_r9_five_cycles: assert property (@(posedge clk) disable iff (rst)
        (sc == SC_W'(4) && (ir.opc == OP_NOP5 || ir.opc == OP_NOP6))
        |=> (sc == '0 && $stable(acc) && $stable(e)));

    a_r12_flag_set: assert property (@(posedge clk) disable iff (rst)
        in_load |=> in_full);

endmodule

bind acc_seq_top acc_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sc        (sc_out),
    .pc        (pc_out),
    .acc       (acc_out),
    .e         (e_out),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .in_load   (in_load),
    .in_full   (in_full),
    .ir        (ir_q)
);

// File: tb/tb_acc_seq_top.sv
module tb_acc_seq_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic [15:0] mem_rdata;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic        in_load = 1'b0;
    logic [7:0]  in_char = '0;
    logic        in_full;
    logic [15:0] acc_out;
    logic        e_out;
    logic [11:0] pc_out;
    logic [2:0]  sc_out;

    logic [15:0] mem [0:4095];

    int checks   = 0;
    int failures = 0;

    logic [11:0] m_pc;
    logic [15:0] m_ac;
    logic        m_e;
    logic [7:0]  m_hold;
    logic        m_full;

    always #2 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    acc_seq_top dut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .in_load   (in_load),
        .in_char   (in_char),
        .in_full   (in_full),
        .acc_out   (acc_out),
        .e_out     (e_out),
        .pc_out    (pc_out),
        .sc_out    (sc_out)
    );

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures + 1);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Runs one instruction placed at the model PC; called at a negedge with step 0.
    task automatic run(input logic [15:0] w, input int load_cyc, input logic [7:0] ch,
                       input string tag);
        logic [2:0]  opc;
        logic [11:0] ea;
        logic [11:0] pc_old;
        logic [15:0] d;
        logic [16:0] s;
        logic        is_mem;
        logic        is_sta;
        int          n;
        opc    = w[14:12];
        is_mem = (opc != 3'b111);
        is_sta = (opc == 3'b011);
        mem[m_pc] = w;
        pc_old = m_pc;
        m_pc   = m_pc + 1'b1;
        ea = w[11:0];
        if (is_mem && w[15]) ea = mem[w[11:0]][11:0];
        d = mem[ea];
        if (load_cyc >= 0 && load_cyc < 3) begin
            m_hold = ch;
            m_full = 1'b1;
        end
        n = 4;
        if (is_mem) begin
            case (opc)
                3'b000: begin n = 6; m_ac = m_ac & d; end
                3'b001: begin n = 6; s = {1'b0, m_ac} + {1'b0, d}; {m_e, m_ac} = s; end
                3'b010: begin n = 6; m_ac = d; end
                3'b100: begin n = 5; m_pc = ea; end
                default: n = 5;
            endcase
        end else if (!w[15]) begin
            if (w[11]) m_ac = '0;
            if (w[10]) m_e = 1'b0;
            if (w[9])  m_ac = ~m_ac;
            if (w[8])  m_e = ~m_e;
        end else if (w[11]) begin
            m_ac[7:0] = m_hold;
            m_full    = 1'b0;
        end
        if (load_cyc >= 3) begin
            m_hold = ch;
            m_full = 1'b1;
        end
        for (int cyc = 0; cyc < n; cyc++) begin
            chk({tag, " step"}, 32'(sc_out), 32'(cyc));
            chk("R7 write enable", 32'(mem_we), 32'(is_sta && cyc == 4));
            if (mem_we) mem[mem_addr] = mem_wdata;
            if (cyc == 1) chk("R2 fetch address", 32'(mem_addr), 32'(pc_old));
            if (cyc == 4) chk(w[15] ? "R4 indirect address" : "R3 direct address",
                              32'(mem_addr), 32'(ea));
            in_load = (cyc == load_cyc);
            in_char = ch;
            @(negedge clk);
        end
        in_load = 1'b0;
        chk({tag, " length"}, 32'(sc_out), 32'd0);
        chk(opc == 3'b100 ? "R8 pc" : "R2 pc", 32'(pc_out), 32'(m_pc));
        chk({tag, " acc"}, 32'(acc_out), 32'(m_ac));
        chk({tag, " e"}, 32'(e_out), 32'(m_e));
        chk("R12 in_full", 32'(in_full), 32'(m_full));
        if (is_sta) chk("R7 stored word", 32'(mem[ea]), 32'(m_ac));
    endtask

    function automatic logic [15:0] pat(input int i, input int k);
        return 16'(i * 16'h1357 + k * 16'h0F1D) ^ 16'(i << 9);
    endfunction

    initial begin
        for (int a = 0; a < 4096; a++) mem[a] = '0;
        repeat (3) @(negedge clk);
        chk("R1 pc", 32'(pc_out), 0);
        chk("R1 acc", 32'(acc_out), 0);
        chk("R1 e", 32'(e_out), 0);
        chk("R1 sc", 32'(sc_out), 0);
        chk("R1 in_full", 32'(in_full), 0);
        chk("R1 we", 32'(mem_we), 0);
        rst = 1'b0;
        m_pc = '0; m_ac = '0; m_e = 1'b0; m_hold = '0; m_full = 1'b0;

        // ADD sweep, direct and indirect, with carry corners
        for (int i = 0; i < 51; i++) begin
            logic [15:0] a, b;
            a = pat(i, 1);
            b = pat(i, 7);
            if (i == 48) begin a = 16'hFFFF; b = 16'h0001; end
            if (i == 49) begin a = 16'h8000; b = 16'h8000; end
            if (i == 50) begin a = 16'h0000; b = 16'h0000; end
            mem[12'h900] = a;
            mem[12'h901] = b;
            mem[12'hA00] = 16'hF901;
            run(16'h2900, -1, 8'h00, "R6 LDA");
            if (i % 2 == 1) run(16'h9A00, -1, 8'h00, "R5 ADD indirect R4");
            else            run(16'h1901, -1, 8'h00, "R5 ADD direct R3");
        end

        // AND sweep
        for (int i = 0; i < 16; i++) begin
            mem[12'h901] = pat(i, 3);
            mem[12'h902] = pat(i, 11);
            mem[12'hA01] = 16'h3902;
            run(16'h2901, -1, 8'h00, "R6 LDA");
            if (i % 2 == 1) run(16'h8A01, -1, 8'h00, "R6 AND indirect");
            else            run(16'h0902, -1, 8'h00, "R6 AND direct");
        end

        // STA direct and indirect
        for (int i = 0; i < 8; i++) begin
            mem[12'h900] = pat(i, 5);
            mem[12'hA02] = 16'h0B10 + 16'(i);
            run(16'h2900, -1, 8'h00, "R6 LDA");
            run(16'h3B00 + 16'(i), -1, 8'h00, "R7 STA direct");
            run(16'hBA02, -1, 8'h00, "R7 STA indirect R4");
        end

        // opcodes 101 and 110 leave state alone
        mem[12'h900] = 16'h5A5A;
        run(16'h5900, -1, 8'h00, "R9 op5");
        run(16'h6900, -1, 8'h00, "R9 op6");
        chk("R9 memory untouched", 32'(mem[12'h900]), 32'h5A5A);

        // branches
        run(16'h4400, -1, 8'h00, "R8 BUN direct");
        mem[12'hA03] = 16'h7200;
        run(16'hCA03, -1, 8'h00, "R8 BUN indirect");

        // register operation sweep over all four control bits
        for (int v = 0; v < 3; v++) begin
            mem[12'h900] = (v == 0) ? 16'h0000 : (v == 1) ? 16'h1234 : 16'hFFFF;
            run(16'h2900, -1, 8'h00, "R6 LDA");
            for (int m = 0; m < 16; m++) run(16'h7000 | 16'(m << 8), -1, 8'h00, "R10 regop");
        end

        // input transfers
        mem[12'h900] = 16'hC3C3;
        run(16'h2900, 2, 8'h5A, "R12 load during LDA");
        run(16'hF800, -1, 8'h00, "R11 INP");
        run(16'h2900, 1, 8'h77, "R12 load during LDA");
        run(16'hF400, -1, 8'h00, "R11 io without read bit");
        run(16'hF800, 3, 8'h33, "R12 set wins over clear");
        run(16'hF800, -1, 8'h00, "R11 INP after set-wins");
        for (int k = 0; k < 16; k++) begin
            mem[12'h900] = pat(k, 9);
            run(16'h2900, k % 3, 8'(k * 17), "R12 load");
            run(16'hF800, -1, 8'h00, "R11 INP sweep");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule